// File: doc/BRIEF.md
# GPIO Pad Event Detector Bank

This block serves a bank of general-purpose pads (up to 32) that share one interrupt group. Each pad owns a configuration word that sets its function, its output driver, its receiver and the kind of input event that should be recorded. The pad input is synchronized, optionally inverted, and then fed to a per-pad event detector. The detector works in one of four modes: level, rising edge, both edges, or off. A detected event sets that pad's bit in a shared status register.

Software reaches the block through a simple word-addressed register port. It clears status bits by writing ones to them, and it selects which bits may raise the interrupt through an enable register. The interrupt output is a registered OR over the status bits that are also enabled. A falling-edge trigger is built from the rising-edge mode plus inversion. An active-low trigger is built from the level mode plus inversion.

Top module: `gpio_event_bank`

## Requirements
- R1: After reset, the status, enable and interrupt output are all zero. Every pad configuration word reads 0x0400_0100: event select = off, TX disabled, RX enabled, GPIO function, no inversion, TX state 0, and RX state equal to the synchronized input.
- R2: With event select = 0 (level), the status bit is set on every clock in which the conditioned input is 1. A clear written while the input stays high is overridden.
- R3: With event select = 1 (edge), the status bit is set once per 0-to-1 transition of the conditioned input. A steady level or a 1-to-0 transition sets nothing.
- R4: With event select = 3 (both), the status bit is set on any transition of the synchronized input.
- R5: With event select = 2 (off), input activity never sets the status bit.
- R6: The invert bit (bit 23) inverts the synchronized input before detection, so edge mode with inversion fires on a falling input and level mode with inversion fires on a low input. Toggling the invert bit by itself creates no edge.
- R7: The RX state bit (bit 1) reads the pad input through a two-flop synchronizer, so it reflects a change after two clocks. Writes to RX state are ignored.
- R8: Writing to the status register (word address 2^(ADDR_W-1)) clears each bit written as 1 and leaves the others. An event in the same cycle wins over the clear.
- R9: The enable register sits at word address 2^(ADDR_W-1)+1. The interrupt output equals, one clock later, the OR of status AND enable.
- R10: Clearing a stale status bit and then setting its enable bit on the next write raises no interrupt.
- R11: The pad output enable is 1 only when pad mode (bits 13:10) is 0 and TX disable (bit 8) is 0. The pad output then carries TX state (bit 0) and is 0 otherwise.
- R12: RX disable (bit 9) set, or a pad mode other than 0, suppresses event detection for that pad.
- R13: Word addresses that map to no register read as 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| padIn | input | NUM_PADS | Raw pad inputs, asynchronous |
| padOut | output | NUM_PADS | Pad output values |
| padOe | output | NUM_PADS | Pad output enables |
| regWe | input | 1 | Register write strobe |
| regAddr | input | ADDR_W | Register word address |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data, combinational from regAddr |
| irqOut | output | 1 | Registered group interrupt |

## Verification
The bench aims at the cases where level and edge behaviour diverge. A held level input must survive a clear, because a design that let the clear win would drop an active-high request. Edge mode must stay quiet on a falling input and when only the invert bit is flipped, because a detector built on the inverted history would fire spuriously. The clear-then-enable order is checked over several clocks, where an unregistered or stale path would raise the interrupt. The exact synchronizer latency is checked at the RX state bit, because a missing or extra flop shifts every event by a clock and the per-cycle model comparison catches that shift.

// File: rtl/gpio_event_pkg.sv
package gpio_event_pkg;
  localparam int MAX_PADS = 32;
  localparam int IDX_W    = $clog2(MAX_PADS);
  localparam int DATA_W   = 32;

  typedef enum logic [1:0] {
    EV_LEVEL = 2'd0,
    EV_RISE  = 2'd1,
    EV_OFF   = 2'd2,
    EV_BOTH  = 2'd3
  } evSel_e;

  typedef enum logic [1:0] {
    RD_NONE,
    RD_CFG,
    RD_STAT,
    RD_ENA
  } rdKind_e;

  typedef struct packed {
    evSel_e     evSel;
    logic       rxInv;
    logic [3:0] mode;
    logic       rxDis;
    logic       txDis;
    logic       txState;
  } padCfg_t;

  typedef struct packed {
    logic [MAX_PADS-1:0] cfgWr;
    logic                statClr;
    logic                enaWr;
    rdKind_e             rdKind;
    logic [IDX_W-1:0]    rdIdx;
  } regStrobe_t;

  localparam padCfg_t CFG_RST = '{evSel: EV_OFF, rxInv: 1'b0, mode: 4'd0,
                                  rxDis: 1'b0, txDis: 1'b1, txState: 1'b0};

  function automatic logic [DATA_W-1:0] packCfg(padCfg_t c, logic rx);
    logic [DATA_W-1:0] w;
    w        = '0;
    w[0]     = c.txState;
    w[1]     = rx;
    w[8]     = c.txDis;
    w[9]     = c.rxDis;
    w[13:10] = c.mode;
    w[23]    = c.rxInv;
    w[26:25] = c.evSel;
    return w;
  endfunction

  function automatic padCfg_t unpackCfg(logic [DATA_W-1:0] w);
    padCfg_t c;
    c.txState = w[0];
    c.txDis   = w[8];
    c.rxDis   = w[9];
    c.mode    = w[13:10];
    c.rxInv   = w[23];
    c.evSel   = evSel_e'(w[26:25]);
    return c;
  endfunction
endpackage

// File: rtl/gpio_event_ctrl.sv
module gpio_event_ctrl
  import gpio_event_pkg::*;
#(
  parameter int NUM_PADS = 32,
  parameter int ADDR_W   = 7
) (
  input  logic              regWe,
  input  logic [ADDR_W-1:0] regAddr,
  output regStrobe_t        strb
);
  localparam logic [ADDR_W-1:0] STAT_ADDR = ADDR_W'(1) << (ADDR_W - 1);
  localparam logic [ADDR_W-1:0] ENA_ADDR  = STAT_ADDR + ADDR_W'(1);
  localparam logic [ADDR_W-1:0] PAD_LIMIT = ADDR_W'(NUM_PADS);

  always_comb begin
    strb        = '0;
    strb.rdKind = RD_NONE;
    if (regAddr < PAD_LIMIT) begin
      strb.rdKind                            = RD_CFG;
      strb.rdIdx                             = regAddr[IDX_W-1:0];
      strb.cfgWr[regAddr[IDX_W-1:0]]         = regWe;
    end else if (regAddr == STAT_ADDR) begin
      strb.rdKind  = RD_STAT;
      strb.statClr = regWe;
    end else if (regAddr == ENA_ADDR) begin
      strb.rdKind = RD_ENA;
      strb.enaWr  = regWe;
    end
  end
endmodule

// File: rtl/gpio_event_pad.sv
module gpio_event_pad
  import gpio_event_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    padIn,
  input  logic    cfgWr,
  input  padCfg_t wrCfg,
  output padCfg_t cfgQ,
  output logic    rxSync,
  output logic    evt,
  output logic    padOut,
  output logic    padOe
);
  logic s1Q, s2Q, prevQ;
  logic cond, condPrev, live;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      s1Q   <= 1'b0;
      s2Q   <= 1'b0;
      prevQ <= 1'b0;
    end else begin
      s1Q   <= padIn;
      s2Q   <= s1Q;
      prevQ <= s2Q;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      cfgQ <= CFG_RST;
    else if (cfgWr) cfgQ <= wrCfg;
  end

  assign rxSync   = s2Q;
  assign cond     = s2Q ^ cfgQ.rxInv;
  assign condPrev = prevQ ^ cfgQ.rxInv;
  assign live     = (cfgQ.mode == 4'd0) && !cfgQ.rxDis;

  always_comb begin
    unique case (cfgQ.evSel)
      EV_LEVEL: evt = live && cond;
      EV_RISE:  evt = live && cond && !condPrev;
      EV_BOTH:  evt = live && (s2Q != prevQ);
      default:  evt = 1'b0;
    endcase
  end

  assign padOe  = (cfgQ.mode == 4'd0) && !cfgQ.txDis;
  assign padOut = padOe && cfgQ.txState;
endmodule

// File: rtl/gpio_event_dpath.sv
module gpio_event_dpath
  import gpio_event_pkg::*;
#(
  parameter int NUM_PADS = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_PADS-1:0] padIn,
  input  logic [DATA_W-1:0]   regWdata,
  input  regStrobe_t          strb,
  output logic [NUM_PADS-1:0] padOut,
  output logic [NUM_PADS-1:0] padOe,
  output logic [DATA_W-1:0]   regRdata,
  output logic [NUM_PADS-1:0] statusQ,
  output logic [NUM_PADS-1:0] enableQ,
  output logic                irqQ
);
  padCfg_t             cfgArr [NUM_PADS];
  logic [NUM_PADS-1:0] rxV;
  logic [NUM_PADS-1:0] evtV;
  logic [NUM_PADS-1:0] clrMask;
  padCfg_t             wrCfg;

  assign wrCfg   = unpackCfg(regWdata);
  assign clrMask = strb.statClr ? regWdata[NUM_PADS-1:0] : '0;

  for (genvar p = 0; p < NUM_PADS; p++) begin : g_pad
    gpio_event_pad u_pad (
      .clk    (clk),
      .rstN   (rstN),
      .padIn  (padIn[p]),
      .cfgWr  (strb.cfgWr[p]),
      .wrCfg  (wrCfg),
      .cfgQ   (cfgArr[p]),
      .rxSync (rxV[p]),
      .evt    (evtV[p]),
      .padOut (padOut[p]),
      .padOe  (padOe[p])
    );
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statusQ <= '0;
      enableQ <= '0;
      irqQ    <= 1'b0;
    end else begin
      statusQ <= (statusQ & ~clrMask) | evtV;
      if (strb.enaWr) enableQ <= regWdata[NUM_PADS-1:0];
      irqQ    <= |(statusQ & enableQ);
    end
  end

  always_comb begin
    unique case (strb.rdKind)
      RD_CFG:  regRdata = packCfg(cfgArr[strb.rdIdx], rxV[strb.rdIdx]);
      RD_STAT: regRdata = DATA_W'(statusQ);
      RD_ENA:  regRdata = DATA_W'(enableQ);
      default: regRdata = '0;
    endcase
  end
endmodule

// File: rtl/gpio_event_bank.sv
module gpio_event_bank
  import gpio_event_pkg::*;
#(
  parameter int NUM_PADS = 32,
  parameter int ADDR_W   = 7
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_PADS-1:0] padIn,
  output logic [NUM_PADS-1:0] padOut,
  output logic [NUM_PADS-1:0] padOe,
  input  logic                regWe,
  input  logic [ADDR_W-1:0]   regAddr,
  input  logic [31:0]         regWdata,
  output logic [31:0]         regRdata,
  output logic                irqOut
);
  regStrobe_t          strb;
  logic [NUM_PADS-1:0] statusQ;
  logic [NUM_PADS-1:0] enableQ;

  gpio_event_ctrl #(.NUM_PADS(NUM_PADS), .ADDR_W(ADDR_W)) u_ctrl (
    .regWe   (regWe),
    .regAddr (regAddr),
    .strb    (strb)
  );

  gpio_event_dpath #(.NUM_PADS(NUM_PADS)) u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .padIn    (padIn),
    .regWdata (regWdata),
    .strb     (strb),
    .padOut   (padOut),
    .padOe    (padOe),
    .regRdata (regRdata),
    .statusQ  (statusQ),
    .enableQ  (enableQ),
    .irqQ     (irqOut)
  );
endmodule

module gpio_event_chk #(
  parameter int NUM_PADS = 32,
  parameter int ADDR_W   = 7
) (
  input logic                clk,
  input logic                rstN,
  input logic [NUM_PADS-1:0] padOut,
  input logic [NUM_PADS-1:0] padOe,
  input logic                regWe,
  input logic [ADDR_W-1:0]   regAddr,
  input logic [31:0]         regWdata,
  input logic [NUM_PADS-1:0] statusQ,
  input logic [NUM_PADS-1:0] enableQ,
  input logic                irqOut
);
  localparam logic [ADDR_W-1:0] ENA_ADDR = (ADDR_W'(1) << (ADDR_W - 1)) + ADDR_W'(1);

  p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (statusQ == '0) && (enableQ == '0) && !irqOut);

  p_irq_raise_r9: assert property (@(posedge clk) disable iff (!rstN)
    $past(|(statusQ & enableQ)) |-> irqOut);

  p_irq_quiet_r10: assert property (@(posedge clk) disable iff (!rstN)
    $past(~|(statusQ & enableQ)) |-> !irqOut);

  p_ena_write_r9: assert property (@(posedge clk) disable iff (!rstN)
    $past(regWe && (regAddr == ENA_ADDR)) |-> (enableQ == $past(regWdata[NUM_PADS-1:0])));

  p_out_needs_oe_r11: assert property (@(posedge clk) disable iff (!rstN)
    (padOut & ~padOe) == '0);
endmodule

bind gpio_event_bank gpio_event_chk #(.NUM_PADS(NUM_PADS), .ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .padOut   (padOut),
  .padOe    (padOe),
  .regWe    (regWe),
  .regAddr  (regAddr),
  .regWdata (regWdata),
  .statusQ  (statusQ),
  .enableQ  (enableQ),
  .irqOut   (irqOut)
);

// File: tb/tb_gpio_event_bank.sv
module tb_gpio_event_bank;
  localparam int NP = 32;
  localparam int AW = 7;
  localparam logic [AW-1:0] STAT_A = 7'd64;
  localparam logic [AW-1:0] ENA_A  = 7'd65;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [NP-1:0] padIn = '0;
  logic [NP-1:0] padOut, padOe;
  logic          regWe = 1'b0;
  logic [AW-1:0] regAddr = '0;
  logic [31:0]   regWdata = '0;
  logic [31:0]   regRdata;
  logic          irqOut;

  int checks = 0;
  int errors = 0;
  bit chkOn = 1'b0;
  bit done  = 1'b0;
  int cycles = 0;

  always #4 clk = ~clk;

  gpio_event_bank #(.NUM_PADS(NP), .ADDR_W(AW)) dut (
    .clk(clk), .rstN(rstN), .padIn(padIn), .padOut(padOut), .padOe(padOe),
    .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata),
    .regRdata(regRdata), .irqOut(irqOut)
  );

  // behavioural reference state
  bit [1:0]    mEv   [NP];
  bit          mInv  [NP];
  bit          mRxDis[NP];
  bit          mTxDis[NP];
  bit          mTxSt [NP];
  bit [3:0]    mMode [NP];
  bit [NP-1:0] mS1, mS2, mPrev, mStat, mEna;
  bit          mIrq;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] mRead(logic [AW-1:0] a);
    logic [31:0] w = '0;
    if (a < NP) begin
      w[0] = mTxSt[a]; w[1] = mS2[a]; w[8] = mTxDis[a]; w[9] = mRxDis[a];
      w[13:10] = mMode[a]; w[23] = mInv[a]; w[26:25] = mEv[a];
    end else if (a == STAT_A) w = mStat;
    else if (a == ENA_A) w = mEna;
    return w;
  endfunction

  always @(posedge clk) begin
    automatic bit [NP-1:0] setV = '0;
    automatic bit [NP-1:0] clr  = '0;
    if (!rstN) begin
      for (int i = 0; i < NP; i++) begin
        mEv[i] = 2'd2; mInv[i] = 0; mRxDis[i] = 0; mTxDis[i] = 1; mTxSt[i] = 0; mMode[i] = 0;
      end
      mS1 = '0; mS2 = '0; mPrev = '0; mStat = '0; mEna = '0; mIrq = 0;
    end else begin
      for (int i = 0; i < NP; i++) begin
        automatic bit c  = mS2[i] ^ mInv[i];
        automatic bit cp = mPrev[i] ^ mInv[i];
        if (mMode[i] == 0 && !mRxDis[i]) begin
          if (mEv[i] == 0) setV[i] = c;
          else if (mEv[i] == 1) setV[i] = c && !cp;
          else if (mEv[i] == 3) setV[i] = mS2[i] != mPrev[i];
        end
      end
      if (regWe && regAddr == STAT_A) clr = regWdata;
      mIrq  = |(mStat & mEna);
      mStat = (mStat & ~clr) | setV;
      if (regWe && regAddr == ENA_A) mEna = regWdata;
      if (regWe && regAddr < NP) begin
        mTxSt[regAddr] = regWdata[0]; mTxDis[regAddr] = regWdata[8];
        mRxDis[regAddr] = regWdata[9]; mMode[regAddr] = regWdata[13:10];
        mInv[regAddr] = regWdata[23]; mEv[regAddr] = regWdata[26:25];
      end
      mPrev = mS2; mS2 = mS1; mS1 = padIn;
    end
  end

  // per-cycle comparison against the reference, away from the active edge
  always @(negedge clk) begin
    if (chkOn && !done) begin
      automatic logic [NP-1:0] oe, po;
      for (int i = 0; i < NP; i++) begin
        oe[i] = (mMode[i] == 0) && !mTxDis[i];
        po[i] = oe[i] && mTxSt[i];
      end
      check("R9 irq per cycle", 32'(irqOut), 32'(mIrq));
      check("R11 oe per cycle", padOe, oe);
      check("R11 out per cycle", padOut, po);
      if (regAddr < NP) check("R7 cfg read per cycle", regRdata, mRead(regAddr));
      else if (regAddr == STAT_A) check("R8 status per cycle", regRdata, mRead(regAddr));
      else if (regAddr == ENA_A) check("R9 enable per cycle", regRdata, mRead(regAddr));
      else check("R13 unmapped per cycle", regRdata, 32'h0);
    end
  end

  task automatic step(int n = 1);
    repeat (n) begin @(negedge clk); #1; end
  endtask

  task automatic wr(logic [AW-1:0] a, logic [31:0] d);
    regAddr = a; regWdata = d; regWe = 1'b1;
    step();
    regWe = 1'b0; regWdata = '0;
  endtask

  task automatic rdExp(logic [AW-1:0] a, logic [31:0] exp, string tag);
    regAddr = a; #1;
    check(tag, regRdata, exp);
  endtask

  task automatic finishRun();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      finishRun();
    end
  end

  initial begin
    step(3);
    // R1: reset state while still held in reset
    rdExp(7'd0, 32'h0400_0100, "R1 cfg reset");
    rdExp(STAT_A, 32'h0, "R1 status reset");
    rdExp(ENA_A, 32'h0, "R1 enable reset");
    check("R1 irq reset", 32'(irqOut), 32'h0);
    rstN = 1'b1;
    step();
    chkOn = 1'b1;

    // R11: output driver control
    wr(7'd3, 32'h0000_0001);
    check("R11 oe enabled", 32'(padOe[3]), 32'h1);
    check("R11 out value", 32'(padOut[3]), 32'h1);
    wr(7'd3, 32'h0000_0401);
    check("R11 oe off in alt mode", 32'(padOe[3]), 32'h0);

    // R7: synchronizer latency and read-only RX state
    padIn[5] = 1'b1;
    step();
    rdExp(7'd5, 32'h0400_0100, "R7 rx not yet visible");
    step();
    rdExp(7'd5, 32'h0400_0102, "R7 rx visible after two clocks");
    wr(7'd5, 32'h0400_0100);
    rdExp(7'd5, 32'h0400_0102, "R7 rx write ignored");
    padIn[5] = 1'b0;

    // R2/R8: level mode re-asserts over a clear
    wr(7'd2, 32'h0000_0000);
    padIn[2] = 1'b1;
    step(4);
    rdExp(STAT_A, 32'h0000_0004, "R2 level sets status");
    wr(STAT_A, 32'h0000_0004);
    rdExp(STAT_A, 32'h0000_0004, "R8 event wins over clear");
    padIn[2] = 1'b0;
    step(4);
    wr(STAT_A, 32'h0000_0004);
    rdExp(STAT_A, 32'h0, "R8 clear takes effect");

    // R3: rising edge only
    wr(7'd4, 32'h0200_0000);
    padIn[4] = 1'b1;
    step(4);
    rdExp(STAT_A, 32'h0000_0010, "R3 rise sets status");
    wr(STAT_A, 32'h0000_0010);
    step(3);
    rdExp(STAT_A, 32'h0, "R3 steady high no event");
    padIn[4] = 1'b0;
    step(4);
    rdExp(STAT_A, 32'h0, "R3 fall no event");

    // R4: both edges
    wr(7'd6, 32'h0600_0000);
    padIn[6] = 1'b1;
    step(4);
    rdExp(STAT_A, 32'h0000_0040, "R4 rise sets");
    wr(STAT_A, 32'h0000_0040);
    padIn[6] = 1'b0;
    step(4);
    rdExp(STAT_A, 32'h0000_0040, "R4 fall sets");
    wr(STAT_A, 32'h0000_0040);

    // R5: disabled mode ignores activity
    padIn[7] = 1'b1; step(4); padIn[7] = 1'b0; step(4);
    rdExp(STAT_A, 32'h0, "R5 off mode ignores input");

    // R6: inversion
    wr(7'd8, 32'h0200_0000);
    step(3);
    wr(7'd8, 32'h0280_0000);
    step(3);
    rdExp(STAT_A, 32'h0, "R6 invert toggle alone no edge");
    padIn[8] = 1'b1; step(4);
    wr(STAT_A, 32'h0000_0100);
    padIn[8] = 1'b0; step(4);
    rdExp(STAT_A, 32'h0000_0100, "R6 falling edge via invert");
    wr(7'd8, 32'h0080_0000);
    wr(STAT_A, 32'h0000_0100);
    step(2);
    rdExp(STAT_A, 32'h0000_0100, "R6 active low level via invert");
    wr(7'd8, 32'h0400_0100);
    wr(STAT_A, 32'h0000_0100);

    // R12: receiver disable and alternate mode suppress events
    wr(7'd9, 32'h0000_0200);
    padIn[9] = 1'b1; step(4);
    rdExp(STAT_A, 32'h0, "R12 rx disabled no event");
    wr(7'd9, 32'h0000_0800);
    step(4);
    rdExp(STAT_A, 32'h0, "R12 alt mode no event");
    padIn[9] = 1'b0;

    // R9/R10: interrupt gating and clear-before-enable
    padIn[4] = 1'b1; step(4);
    rdExp(STAT_A, 32'h0000_0010, "R10 stale status present");
    check("R9 no irq without enable", 32'(irqOut), 32'h0);
    wr(STAT_A, 32'h0000_0010);
    wr(ENA_A, 32'h0000_0010);
    for (int k = 0; k < 3; k++) begin
      check("R10 no stale irq", 32'(irqOut), 32'h0);
      step();
    end
    padIn[4] = 1'b0; step(3);
    padIn[4] = 1'b1; step(5);
    check("R9 irq raised", 32'(irqOut), 32'h1);
    wr(ENA_A, 32'h0);
    step();
    check("R9 irq drops with enable", 32'(irqOut), 32'h0);
    wr(STAT_A, 32'hFFFF_FFFF);

    // R13: unmapped addresses
    rdExp(7'd40, 32'h0, "R13 unmapped reads zero");
    wr(7'd100, 32'hFFFF_FFFF);
    rdExp(ENA_A, 32'h0, "R13 unmapped write no effect on enable");
    rdExp(7'd9, 32'h0000_0800, "R13 unmapped write no effect on cfg");

    step(4);
    finishRun();
  end
endmodule